// File: doc/BRIEF.md
# Epoch Seconds Clock

This block keeps wall-clock time as a 32-bit count of seconds from midnight at the start of 1 January 1904. A free-running elapsed-seconds counter advances on a prescaled one-cycle tick. A separate offset register holds the difference between the reported time and that counter. The reported time is always offset plus elapsed. Writing the time changes only the offset, so the elapsed count is never disturbed. A host that keeps time from 1970 adds 2082844800 seconds to reach this epoch.

Two commands reach the block through a valid/opcode/length/data interface. A read takes no argument bytes. It takes a snapshot of the time and returns it as four bytes, most significant first, on a byte-serial output. The whole word is held on a parallel output for the length of the reply. A write carries exactly four argument bytes, presented as a 32-bit word whose most significant byte is the first argument byte. Commands with any other argument count do nothing. The command transport and any conversion to calendar dates are left to neighbouring logic.

Top module: `epoch_rtc`

## Requirements
- R1: While reset is asserted, the offset loads from `initOffset` and the elapsed count clears. After reset no reply is active, and a read returns `initOffset` until the first tick.
- R2: Each cycle with `secTick` high advances the elapsed count by one. The reported time is offset plus elapsed, modulo 2^32.
- R3: A read (`cmdIsSet`=0, `cmdLen`=0) sampled at a clock edge starts a reply. `rspValid` is high for the next four cycles. `rspByte` carries bits 31:24, then 23:16, then 15:8, then 7:0. `rspLast` is high only with the fourth byte, and `rspWord` holds the whole snapshot unchanged throughout.
- R4: A read with a nonzero `cmdLen` produces no reply.
- R5: A write (`cmdIsSet`=1, `cmdLen`=4) stores `cmdData` minus the elapsed count as the offset. A later read returns the written value plus the ticks that came after the write.
- R6: A write whose `cmdLen` is not 4 leaves the time unchanged.
- R7: A tick in the same cycle as a write counts as before the write. A read that follows with no further tick returns exactly the written value.
- R8: A tick in the same cycle as a read is not included in that read's snapshot. It is included in later reads.
- R9: A read that arrives while a reply is on its first three bytes is dropped. A read that arrives with the last byte starts a new reply in the next cycle, with no gap. A write is always accepted.
- R10: The time wraps from 0xFFFFFFFF to 0x00000000 on a tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| initOffset | input | 32 | Time loaded into the offset during reset |
| secTick | input | 1 | One-cycle enable, once per second |
| cmdValid | input | 1 | Command present this cycle |
| cmdIsSet | input | 1 | 1 = write time, 0 = read time |
| cmdLen | input | 3 | Argument byte count of the command |
| cmdData | input | 32 | Write argument, first byte in bits 31:24 |
| rspValid | output | 1 | Reply byte valid |
| rspByte | output | 8 | Reply byte, most significant first |
| rspLast | output | 1 | Final byte of the reply |
| rspWord | output | 32 | Snapshot being returned, parallel form |

## Verification
The seconds tick can fall in the same cycle as a write or as a read. The bench drives `secTick` high in the very cycle that a command is sampled. For a write, it then requires the next read to return exactly the written word. For a read, it requires the snapshot to exclude that tick and the following read to include it. A read can also fall on a reply that is still in progress. The bench provokes this by issuing reads mid-reply and on the last byte, and the scoreboard flags any extra, missing or shifted reply.

// File: rtl/epoch_rtc_pkg.sv
package epoch_rtc_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic capture;     // snapshot the current time into the reply word
    logic loadOffset;  // store a new offset from the write argument
  } rtcStrobe_t;
endpackage

// File: rtl/epoch_rtc_ctl.sv
module epoch_rtc_ctl
  import epoch_rtc_pkg::*;
#(
  parameter int NBYTES = 4,
  parameter int LEN_W  = 3,
  localparam int IDX_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic             cmdIsSet,
  input  logic [LEN_W-1:0] cmdLen,
  output rtcStrobe_t       strobe,
  output logic [IDX_W-1:0] byteSel,
  output logic             rspValid,
  output logic             rspLast
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NBYTES - 1);
  localparam logic [LEN_W-1:0] SET_LEN  = LEN_W'(NBYTES);

  logic             activeQ;
  logic [IDX_W-1:0] idxQ;
  logic             onLast;
  logic             getOk;
  logic             setOk;

  assign onLast = activeQ && (idxQ == LAST_IDX);
  assign getOk  = cmdValid && !cmdIsSet && (cmdLen == '0) && (!activeQ || onLast);
  assign setOk  = cmdValid && cmdIsSet && (cmdLen == SET_LEN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      idxQ    <= '0;
    end else if (getOk) begin
      activeQ <= 1'b1;
      idxQ    <= '0;
    end else if (activeQ) begin
      if (onLast) activeQ <= 1'b0;
      else        idxQ    <= idxQ + 1'b1;
    end
  end

  always_comb begin
    strobe.capture    = getOk;
    strobe.loadOffset = setOk;
  end

  assign byteSel  = idxQ;
  assign rspValid = activeQ;
  assign rspLast  = onLast;
endmodule

// File: rtl/epoch_rtc_dp.sv
module epoch_rtc_dp
  import epoch_rtc_pkg::*;
#(
  parameter int TIME_W = 32,
  parameter int BYTE_W = 8,
  localparam int NBYTES = TIME_W / BYTE_W,
  localparam int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TIME_W-1:0] initOffset,
  input  logic              secTick,
  input  logic [TIME_W-1:0] cmdData,
  input  rtcStrobe_t        strobe,
  input  logic [IDX_W-1:0]  byteSel,
  output logic [BYTE_W-1:0] rspByte,
  output logic [TIME_W-1:0] rspWord
);
  logic [TIME_W-1:0] elapsedQ;
  logic [TIME_W-1:0] elapsedNext;
  logic [TIME_W-1:0] offsetQ;
  logic [TIME_W-1:0] wordQ;

  assign elapsedNext = elapsedQ + TIME_W'(secTick);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      elapsedQ <= '0;
      offsetQ  <= initOffset;
      wordQ    <= '0;
    end else begin
      elapsedQ <= elapsedNext;
      // A tick in the same cycle counts before the write
      if (strobe.loadOffset) offsetQ <= cmdData - elapsedNext;
      // The snapshot uses the registered count, so a same-cycle tick is excluded
      if (strobe.capture)    wordQ   <= offsetQ + elapsedQ;
    end
  end

  assign rspByte = wordQ[(NBYTES - 1 - int'(byteSel)) * BYTE_W +: BYTE_W];
  assign rspWord = wordQ;
endmodule

// File: rtl/epoch_rtc.sv
module epoch_rtc
  import epoch_rtc_pkg::*;
#(
  parameter int TIME_W = 32,
  parameter int BYTE_W = 8,
  parameter int LEN_W  = 3,
  localparam int NBYTES = TIME_W / BYTE_W,
  localparam int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TIME_W-1:0] initOffset,
  input  logic              secTick,
  input  logic              cmdValid,
  input  logic              cmdIsSet,
  input  logic [LEN_W-1:0]  cmdLen,
  input  logic [TIME_W-1:0] cmdData,
  output logic              rspValid,
  output logic [BYTE_W-1:0] rspByte,
  output logic              rspLast,
  output logic [TIME_W-1:0] rspWord
);
  rtcStrobe_t       strobe;
  logic [IDX_W-1:0] byteSel;

  epoch_rtc_ctl #(.NBYTES(NBYTES), .LEN_W(LEN_W)) u_ctl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdIsSet(cmdIsSet),
    .cmdLen(cmdLen), .strobe(strobe), .byteSel(byteSel),
    .rspValid(rspValid), .rspLast(rspLast)
  );

  epoch_rtc_dp #(.TIME_W(TIME_W), .BYTE_W(BYTE_W)) u_dp (
    .clk(clk), .rstN(rstN), .initOffset(initOffset), .secTick(secTick),
    .cmdData(cmdData), .strobe(strobe), .byteSel(byteSel),
    .rspByte(rspByte), .rspWord(rspWord)
  );
endmodule

// File: rtl/epoch_rtc_chk.sv
module epoch_rtc_chk #(
  parameter int TIME_W = 32,
  parameter int BYTE_W = 8,
  parameter int LEN_W  = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic              cmdIsSet,
  input logic [LEN_W-1:0]  cmdLen,
  input logic              rspValid,
  input logic              rspLast,
  input logic [BYTE_W-1:0] rspByte,
  input logic [TIME_W-1:0] rspWord
);
  logic readCmd;
  logic badRead;
  assign readCmd = cmdValid && !cmdIsSet && (cmdLen == '0);
  assign badRead = cmdValid && !cmdIsSet && (cmdLen != '0);

  AST_REPLY_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspLast |=> rspValid);                          // R3
  AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspLast |=> $stable(rspWord));                  // R9
  AST_LAST_IMPLIES_VALID: assert property (@(posedge clk) disable iff (!rstN)
    rspLast |-> rspValid);                                       // R3
  AST_FIRST_BYTE_MSB: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid && readCmd |=> rspValid && rspByte == rspWord[TIME_W-1 -: BYTE_W]); // R3
  AST_BAD_READ_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid && badRead |=> !rspValid);                         // R4
  AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rstN)
    rspLast && readCmd |=> rspValid && !rspLast);                // R9
  AST_REPLY_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    rspLast && !readCmd |=> !rspValid);                          // R3
endmodule

bind epoch_rtc epoch_rtc_chk #(.TIME_W(TIME_W), .BYTE_W(BYTE_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdIsSet(cmdIsSet), .cmdLen(cmdLen),
  .rspValid(rspValid), .rspLast(rspLast), .rspByte(rspByte), .rspWord(rspWord)
);

// File: tb/epoch_rtc_test.sv
module epoch_rtc_test;
  localparam logic [31:0] EPOCH_SHIFT = 32'd2082844800;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] initOffset = EPOCH_SHIFT;
  logic        secTick = 1'b0;
  logic        cmdValid = 1'b0;
  logic        cmdIsSet = 1'b0;
  logic [2:0]  cmdLen = '0;
  logic [31:0] cmdData = '0;
  logic        rspValid;
  logic [7:0]  rspByte;
  logic        rspLast;
  logic [31:0] rspWord;

  int errors = 0;
  int checks = 0;
  logic [31:0] expTime;
  logic [31:0] expQ[$];
  string       tagQ[$];
  bit          done = 0;

  always #2 clk = ~clk;

  epoch_rtc uut (
    .clk(clk), .rstN(rstN), .initOffset(initOffset), .secTick(secTick),
    .cmdValid(cmdValid), .cmdIsSet(cmdIsSet), .cmdLen(cmdLen), .cmdData(cmdData),
    .rspValid(rspValid), .rspByte(rspByte), .rspLast(rspLast), .rspWord(rspWord)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: assemble reply bytes and compare with the scoreboard
  logic [31:0] asmWord = '0;
  int          byteCnt = 0;
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      asmWord = {asmWord[23:0], rspByte};
      byteCnt++;
      if (rspLast) begin
        if (expQ.size() == 0) begin
          check(0, "R4/R9 unexpected reply", asmWord, 32'h0);
        end else begin
          logic [31:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check(asmWord == e && byteCnt == 4, t, asmWord, e);
          check(rspWord == e, {t, " R3 parallel word"}, rspWord, e);
        end
        byteCnt = 0;
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic sendCmd(input bit isSet, input logic [2:0] len, input logic [31:0] data, input bit tick);
    cmdValid = 1'b1; cmdIsSet = isSet; cmdLen = len; cmdData = data; secTick = tick;
    @(posedge clk); #1;
    cmdValid = 1'b0; secTick = 1'b0;
  endtask

  task automatic doGet(input string tag, input bit tick);
    expQ.push_back(expTime); tagQ.push_back(tag);
    sendCmd(0, 3'd0, 32'h0, tick);
    if (tick) expTime = expTime + 1;
    idle(5);
  endtask

  task automatic doSet(input logic [31:0] v, input logic [2:0] len, input bit tick);
    if (tick) expTime = expTime + 1;
    sendCmd(1, len, v, tick);
    if (len == 3'd4) expTime = v;
    idle(1);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      secTick = 1'b1; @(posedge clk); #1; secTick = 1'b0;
      expTime = expTime + 1;
      idle(1);
    end
  endtask

  task automatic expectQuiet(input int n, input string tag);
    bit seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (rspValid) seen = 1;
    end
    check(!seen, tag, {31'h0, seen}, 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    expTime = EPOCH_SHIFT;
    idle(3);
    @(negedge clk);
    check(rspValid == 1'b0, "R1 no reply in reset", {31'h0, rspValid}, 32'h0);
    rstN = 1'b1;
    idle(2);
    check(rspValid == 1'b0 && rspLast == 1'b0, "R1 idle after reset", {31'h0, rspValid}, 32'h0);
    doGet("R1 read returns initial offset", 0);

    ticks(3);
    doGet("R2 three ticks added", 0);

    // R4: reads with argument bytes are silent
    sendCmd(0, 3'd1, 32'h0, 0);
    expectQuiet(6, "R4 read with one argument byte");
    sendCmd(0, 3'd4, 32'h0, 0);
    expectQuiet(6, "R4 read with four argument bytes");

    // R5: write then ticks
    doSet(32'h1234_5678, 3'd4, 0);
    doGet("R5 read after write", 0);
    ticks(2);
    doGet("R5 write plus later ticks", 0);

    // R6: bad lengths ignored
    doSet(32'hDEAD_BEEF, 3'd3, 0);
    doSet(32'hDEAD_BEEF, 3'd0, 0);
    doSet(32'hDEAD_BEEF, 3'd5, 0);
    doGet("R6 bad write lengths ignored", 0);

    // R7: tick coincident with write
    doSet(32'hA5A5_0000, 3'd4, 1);
    doGet("R7 tick with write counts before it", 0);

    // R8: tick coincident with read
    doGet("R8 snapshot excludes same-cycle tick", 1);
    doGet("R8 later read includes it", 0);

    // R9: read mid-reply dropped, read on last byte chained
    doSet(32'h0102_0304, 3'd4, 0);
    expQ.push_back(expTime); tagQ.push_back("R9 first reply");
    sendCmd(0, 3'd0, 32'h0, 0);       // sampled at edge E1
    sendCmd(0, 3'd0, 32'h0, 0);       // E2: first byte showing, dropped
    idle(1);                           // E3
    sendCmd(0, 3'd0, 32'h0, 0);       // E4: third byte showing, dropped
    expQ.push_back(expTime); tagQ.push_back("R9 chained reply on last byte");
    sendCmd(0, 3'd0, 32'h0, 0);       // E5: last byte showing, accepted
    idle(6);
    expectQuiet(4, "R9 no reply from dropped reads");

    // R10: wrap
    doSet(32'hFFFF_FFFE, 3'd4, 0);
    ticks(2);
    doGet("R10 wrap to zero", 0);
    ticks(1);
    doGet("R10 count continues after wrap", 0);

    // R1: reset reloads the offset and clears the elapsed count
    initOffset = 32'h0000_ABCD;
    rstN = 1'b0; idle(2); rstN = 1'b1; idle(1);
    expTime = 32'h0000_ABCD;
    doGet("R1 read after second reset", 0);

    idle(4);
    check(expQ.size() == 0, "R3 all expected replies seen", expQ.size(), 32'h0);
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule